// File: doc/BRIEF.md
# FIFO Idle-Data Watchdog

This block sits next to a receive FIFO that a parallel-port channel fills. It tracks how long the FIFO has held data without a new write arriving. A two-stage timebase paces the watch. The first stage is a clock prescaler that makes a coarse tick. The second stage divides that tick by ten to make a timer step. When the FIFO holds data and four steps pass with no accepted write, the block raises an idle ("stale") flag. It raises a single-byte flag when that idle data is exactly one byte. A sticky timeout flag latches the idle event until software clears it.

An 8-bit control word is written and read through a plain port. It carries two test bits that shorten the timebase, a mask that hides the idle-based flags, a toggle-to-clear bit for the timeout latch, and a lock that stops the FIFO from taking data. The channel offers bytes on a valid/ready pair. A byte is accepted in a cycle where `wr_valid` and `wr_ready` are both high, and `wr_push` tells the FIFO storage to take it. The writer must hold its byte while `wr_ready` is low. `wr_ready` is low while the lock is set or the FIFO is full.

Top module: `fifo_idle_watch`

## Requirements
- R1: With both shorten bits clear, the prescaler ticks every 250 clocks and the timer steps on every tenth tick, so every 2500 clocks. `idle_o` rises between 3×2500+1 and 4×2500 clocks after the last accepted write.
- R2: With control bit 7 set, the prescaler ticks every 2 clocks, so a step comes every 20 clocks. `idle_o` rises between 61 and 80 clocks after a write.
- R3: Control bit 6 bypasses the divide-by-ten stage, so the timer steps on every tick. With bits 7 and 6 both set, it steps every 2 clocks and `idle_o` rises 7 or 8 clocks after a write.
- R4: With control bit 4 set, or with `fifo_level` equal to DEPTH (16), `wr_ready` is 0. A write offered while `wr_ready` is 0 is not accepted and does not restart the timer.
- R5: With control bit 5 set, `idle_o` and `single_o` are both 0, whatever the idle condition is.
- R6: `single_o` is 1 exactly when `idle_o` is 1, `fifo_level` is 1 and control bit 3 is 0. With more bytes in the FIFO it stays 0.
- R7: The timeout flag `tmo_o` sets one clock after the unmasked idle condition appears while control bit 3 is 0. A 0-to-1 change of bit 3 clears it on the next clock. While bit 3 stays 1, the flag stays 0 and `single_o` stays 0.
- R8: After reset every control bit and every output flag reads 0 and `wr_ready` is 1. Control bits 2 and 0 always read back 0. Bit 1 is stored and read back but has no effect.
- R9: An accepted write clears the timer, so `idle_o` is 0 in the cycle after it. While `fifo_level` is 0 the timer is held at zero and `idle_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 8 | Control word write data |
| cfg_rdata | output | 8 | Control word read back |
| wr_valid | input | 1 | Channel offers a byte |
| wr_ready | output | 1 | FIFO can take a byte |
| wr_push | output | 1 | Byte accepted this cycle |
| fifo_level | input | 5 | Bytes currently held in the FIFO |
| idle_o | output | 1 | Masked idle-data flag |
| single_o | output | 1 | Idle data is a single byte |
| tmo_o | output | 1 | Latched timeout flag |

## Verification
The hardest case to reach from the ports is the full-length idle timeout. It needs four steps of a 2500-clock timebase, and the prescaler phase at the moment of the write is unknown. The stimulus first sets both test bits and works through the flags and the latch with 2-clock steps. It then runs each timebase mode on its own, once each, and checks a window bounded by three and four step periods after the write. This way the prescaler phase never needs to be known.

// File: rtl/fiw_pkg.sv
package fiw_pkg;

  // Control word layout; positions are decoded by the datapath below.
  localparam int CFG_W        = 8;
  localparam int B_SHORT_TICK = 7;
  localparam int B_SHORT_STEP = 6;
  localparam int B_MASK_IDLE  = 5;
  localparam int B_LOCK       = 4;
  localparam int B_CLR_TMO    = 3;
  localparam int B_SPARE      = 1;

  localparam logic [CFG_W-1:0] CFG_WRITABLE = 8'hFA;

  typedef struct packed {
    logic short_tick;
    logic short_step;
    logic mask_idle;
    logic lock;
    logic clr_tmo;
    logic spare;
  } cfg_t;

endpackage

// File: rtl/fiw_cfg_reg.sv
module fiw_cfg_reg
  import fiw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output cfg_t             cfg
);

  logic [CFG_W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= wdata & CFG_WRITABLE;
  end

  assign rdata = q & CFG_WRITABLE;

  always_comb begin
    cfg.short_tick = q[B_SHORT_TICK];
    cfg.short_step = q[B_SHORT_STEP];
    cfg.mask_idle  = q[B_MASK_IDLE];
    cfg.lock       = q[B_LOCK];
    cfg.clr_tmo    = q[B_CLR_TMO];
    cfg.spare      = q[B_SPARE];
  end

endmodule

// File: rtl/fiw_timebase.sv
module fiw_timebase #(
  parameter int TICK_DIV       = 250,
  parameter int TICK_DIV_SHORT = 2,
  parameter int STEP_DIV       = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic short_tick,
  input  logic short_step,
  output logic step
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [PW-1:0] pcnt;
  logic [PW-1:0] plimit;
  logic          tick;

  assign plimit = short_tick ? PW'(TICK_DIV_SHORT - 1) : PW'(TICK_DIV - 1);
  // >= lets a counter left above a shortened limit wrap at once.
  assign tick   = (pcnt >= plimit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end

  generate
    if (STEP_DIV > 1) begin : g_div
      localparam int DW = $clog2(STEP_DIV);
      logic [DW-1:0] dcnt;
      logic          dwrap;

      assign dwrap = (dcnt == DW'(STEP_DIV - 1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    dcnt <= '0;
        else if (tick) dcnt <= dwrap ? '0 : dcnt + 1'b1;
      end

      assign step = tick & (short_step | dwrap);
    end else begin : g_nodiv
      logic unused_ok;
      assign unused_ok = short_step;
      assign step      = tick;
    end
  endgenerate

endmodule

// File: rtl/fiw_idle_ctr.sv
module fiw_idle_ctr #(
  parameter int TERM = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic restart,
  input  logic empty,
  output logic at_term
);

  localparam int CW = $clog2(TERM + 1);

  logic [CW-1:0] cnt;

  assign at_term = (cnt == CW'(TERM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (restart || empty)   cnt <= '0;
    else if (step && !at_term)   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/fiw_tmo_latch.sv
module fiw_tmo_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_bit,
  input  logic set_cond,
  output logic tmo
);

  logic clr_prev;
  logic clr_rise;

  assign clr_rise = clr_bit & ~clr_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clr_prev <= 1'b0;
      tmo      <= 1'b0;
    end else begin
      clr_prev <= clr_bit;
      if (clr_rise)                 tmo <= 1'b0;
      else if (set_cond && !clr_bit) tmo <= 1'b1;
    end
  end

endmodule

// File: rtl/fifo_idle_watch.sv
module fifo_idle_watch
  import fiw_pkg::*;
#(
  parameter int DEPTH          = 16,
  parameter int TICK_DIV       = 250,
  parameter int TICK_DIV_SHORT = 2,
  parameter int STEP_DIV       = 10,
  parameter int TERM           = 4,
  localparam int LVL_W         = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  input  logic             wr_valid,
  output logic             wr_ready,
  output logic             wr_push,
  input  logic [LVL_W-1:0] fifo_level,
  output logic             idle_o,
  output logic             single_o,
  output logic             tmo_o
);

  cfg_t cfg;
  logic step;
  logic at_term;
  logic empty;
  logic full;
  logic idle_raw;

  fiw_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  fiw_timebase #(
    .TICK_DIV       (TICK_DIV),
    .TICK_DIV_SHORT (TICK_DIV_SHORT),
    .STEP_DIV       (STEP_DIV)
  ) u_tb (
    .clk        (clk),
    .rst_n      (rst_n),
    .short_tick (cfg.short_tick),
    .short_step (cfg.short_step),
    .step       (step)
  );

  assign empty    = (fifo_level == '0);
  assign full     = (fifo_level == LVL_W'(DEPTH));
  assign wr_ready = ~cfg.lock & ~full;
  assign wr_push  = wr_valid & wr_ready;

  fiw_idle_ctr #(.TERM(TERM)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .restart (wr_push),
    .empty   (empty),
    .at_term (at_term)
  );

  assign idle_raw = at_term & ~empty;
  assign idle_o   = idle_raw & ~cfg.mask_idle;
  assign single_o = idle_o & (fifo_level == LVL_W'(1)) & ~cfg.clr_tmo;

  fiw_tmo_latch u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_bit  (cfg.clr_tmo),
    .set_cond (idle_raw),
    .tmo      (tmo_o)
  );

  logic unused_spare;
  assign unused_spare = cfg.spare;

endmodule

// File: rtl/fifo_idle_watch_chk.sv
module fifo_idle_watch_chk #(
  parameter int LVL_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       cfg_rdata,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [LVL_W-1:0] fifo_level,
  input logic             idle_o,
  input logic             single_o,
  input logic             tmo_o
);

  AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata[4] |-> !wr_ready); // R4
  AST_MASK_HIDES: assert property (@(posedge clk) disable iff (!rst_n) cfg_rdata[5] |-> (!idle_o && !single_o)); // R5
  AST_SINGLE_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n) single_o |-> (idle_o && fifo_level == LVL_W'(1))); // R6
  AST_TMO_SETS: assert property (@(posedge clk) disable iff (!rst_n) (idle_o && !cfg_rdata[3]) |=> tmo_o); // R7
  AST_TMO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) $rose(cfg_rdata[3]) |=> !tmo_o); // R7
  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n) (wr_valid && wr_ready) |=> !idle_o); // R9
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (fifo_level == '0) |-> !idle_o); // R9

endmodule

bind fifo_idle_watch fifo_idle_watch_chk #(.LVL_W(LVL_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_rdata  (cfg_rdata),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .fifo_level (fifo_level),
  .idle_o     (idle_o),
  .single_o   (single_o),
  .tmo_o      (tmo_o)
);

// File: tb/fifo_idle_watch_tb_top.sv
module fifo_idle_watch_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic       wr_push;
  logic [4:0] fifo_level = '0;
  logic       idle_o;
  logic       single_o;
  logic       tmo_o;

  always #2.5 clk = ~clk;

  fifo_idle_watch dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_push    (wr_push),
    .fifo_level (fifo_level),
    .idle_o     (idle_o),
    .single_o   (single_o),
    .tmo_o      (tmo_o)
  );

  // observed vector: {rdata[7:0], ready, idle, single, tmo}
  localparam logic [11:0] M_TMO = 12'h001;
  localparam logic [11:0] M_SGL = 12'h002;
  localparam logic [11:0] M_IDL = 12'h004;
  localparam logic [11:0] M_RDY = 12'h008;
  localparam logic [11:0] M_RD  = 12'hFF0;

  typedef struct {
    int          cyc;
    logic [11:0] mask;
    logic [11:0] val;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard driver side: ordered insert
  task automatic expect_at(int c, logic [11:0] m, logic [11:0] v, string tag);
    exp_t e;
    int   i;
    e.cyc = c; e.mask = m; e.val = v; e.tag = tag;
    i = 0;
    while (i < q.size() && q[i].cyc <= c) i++;
    q.insert(i, e);
  endtask

  // monitor: pops due items at the falling edge
  always @(negedge clk) begin
    logic [11:0] obs;
    obs = {cfg_rdata, wr_ready, idle_o, single_o, tmo_o};
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if ((obs & e.mask) !== (e.val & e.mask)) begin
        n_bad++;
        $display("FAIL %s cyc=%0d actual=%03h expected=%03h mask=%03h",
                 e.tag, cyc, obs & e.mask, e.val & e.mask, e.mask);
      end
    end
  end

  task automatic step_clk();
    @(posedge clk); #1;
  endtask

  task automatic cfg_wr(logic [7:0] v);
    step_clk(); cfg_we = 1'b1; cfg_wdata = v;
    step_clk(); cfg_we = 1'b0;
  endtask

  task automatic push_write(output int e0);
    step_clk(); wr_valid = 1'b1;
    step_clk(); wr_valid = 1'b0;
    e0 = cyc;
  endtask

  task automatic drain();
    while (q.size() > 0) step_clk();
  endtask

  task automatic mode_window(logic [7:0] cfg, int per, string tag);
    int e0;
    cfg_wr(cfg);
    push_write(e0);
    expect_at(e0 + 3 * per, M_IDL, 12'h000, {tag, " idle still low"});
    expect_at(e0 + 4 * per, M_IDL, M_IDL,   {tag, " idle risen"});
    drain();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired at cyc=%0d", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int e0;
    int k;
    repeat (4) step_clk();
    rst_n = 1'b1;
    step_clk();
    // R8 reset state
    expect_at(cyc, M_RD | M_RDY | M_IDL | M_SGL | M_TMO, 12'h008, "R8 reset state");
    drain();

    // R8 reserved bits read 0; R4 lock drops ready
    cfg_wr(8'hFF);
    expect_at(cyc, M_RD, 12'hFA0, "R8 reserved bits read zero");
    expect_at(cyc, M_RDY, 12'h000, "R4 lock drops ready");
    drain();

    // R3 both shorten bits: 2-clock steps
    cfg_wr(8'hC0);
    fifo_level = 5'd1;
    push_write(e0);
    expect_at(e0 + 6,  M_IDL, 12'h000, "R3 fast idle not yet");
    expect_at(e0 + 8,  M_IDL | M_SGL, M_IDL | M_SGL, "R6 idle with single byte");
    expect_at(e0 + 10, M_TMO, M_TMO, "R7 timeout latched");
    drain();

    // R6 more than one byte
    step_clk(); fifo_level = 5'd3;
    expect_at(cyc, M_IDL | M_SGL, M_IDL, "R6 single low with 3 bytes");
    drain();
    step_clk(); fifo_level = 5'd1;

    // R5 mask
    cfg_wr(8'hE0);
    expect_at(cyc, M_IDL | M_SGL | M_TMO, M_TMO, "R5 mask hides idle flags");
    drain();
    cfg_wr(8'hC0);
    expect_at(cyc, M_IDL | M_SGL, M_IDL | M_SGL, "R5 unmask restores flags");
    drain();

    // R7 toggle clear and hold
    cfg_wr(8'hC8);
    expect_at(cyc,      M_SGL, 12'h000, "R7 single low while clear held");
    expect_at(cyc + 1,  M_TMO, 12'h000, "R7 rise clears timeout");
    expect_at(cyc + 10, M_IDL | M_SGL | M_TMO, M_IDL, "R7 held clear keeps timeout off");
    drain();
    cfg_wr(8'hC0);
    expect_at(cyc + 1, M_TMO | M_SGL, M_TMO | M_SGL, "R7 timeout sets again after release");
    drain();

    // R9 accepted write restarts
    push_write(e0);
    expect_at(e0,     M_IDL, 12'h000, "R9 write clears timer");
    expect_at(e0 + 8, M_IDL, M_IDL,   "R9 idle after restart");
    drain();

    // R4 locked write not accepted
    cfg_wr(8'hD0);
    push_write(e0);
    expect_at(e0,     M_IDL | M_RDY, M_IDL, "R4 locked write ignored");
    expect_at(e0 + 1, M_IDL, M_IDL, "R4 timer not restarted");
    drain();
    cfg_wr(8'hC0);
    step_clk(); fifo_level = 5'd16;
    expect_at(cyc, M_RDY, 12'h000, "R4 full drops ready");
    drain();
    step_clk(); fifo_level = 5'd1;
    expect_at(cyc, M_RDY, M_RDY, "R4 ready back below full");
    drain();

    // R9 empty holds timer at zero
    step_clk(); fifo_level = 5'd0;
    expect_at(cyc, M_IDL, 12'h000, "R9 empty forces idle low");
    drain();
    repeat (30) step_clk();
    fifo_level = 5'd1;
    k = cyc;
    expect_at(k + 6, M_IDL, 12'h000, "R9 timer was held at zero");
    expect_at(k + 8, M_IDL, M_IDL,   "R9 idle after refill");
    drain();

    // timebase modes
    mode_window(8'h80, 20,   "R2 short tick");
    mode_window(8'h40, 250,  "R3 bypass divider");
    mode_window(8'h02, 2500, "R1 normal timebase");
    expect_at(cyc, M_RD, 12'h020, "R8 spare bit reads back");
    drain();

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule